// File: doc/BRIEF.md
# Page Write-Lock Enforcement Unit

This unit sits on the path from a write command decoder to a byte-wide memory array. It decides, for each write request, whether the addressed byte may change and what value it ends up holding. The rules depend on the protection mode of the zone that the request targets. The decoder supplies that mode with every request. Zones with no protection pass the write through unchanged. A modify-forbidden zone refuses every write. A program-only zone can only clear bits.

In write-lock mode each page of `PAGE_BYTES` bytes carries its own permissions in its first byte. Bit k of that byte guards byte k of the page, and a cleared bit means the byte is frozen. Bit 0 guards the lock byte itself. When the lock byte is still writable, writes to it can only clear bits. Because the unit needs an old byte before it can decide, it reads the array first and then issues the gated write. Each request takes one lookup cycle and one issue cycle. A request that would touch a frozen byte produces a one-cycle rejection pulse in place of a write.

Top module: `wlock_guard`

## Requirements
- R1: After reset, `wr_en`, `rejected` and `rd_en` are low, `wr_len` is zero and `req_ready` is high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the next two cycles. The outcome (`wr_en` or `rejected`) is presented for exactly the single cycle that follows the second clock edge after acceptance. `wr_addr` equals the request address in that cycle.
- R3: Read phase. Mode code 1 is write-lock. In that mode `rd_en` is high in the acceptance cycle and `rd_addr` is the request address with its low log2(`PAGE_BYTES`) bits cleared. Mode code 2 is program-only. In that mode `rd_en` is high in the acceptance cycle and `rd_addr` is the request address. Modes 0 and 3 issue no read. The array returns `rd_data` one cycle after `rd_en`.
- R4: In write-lock mode, the lock byte is the byte at page offset 0 as returned on `rd_data`. A request to page offset k (k ≠ 0) is written with the request data unchanged when bit k of the lock byte is 1. It is refused when that bit is 0.
- R5: In write-lock mode, a request to page offset 0 is refused when bit 0 of the current lock byte is 0. Otherwise the value written is the current lock byte ANDed with the request data.
- R6: A refused request leaves memory unchanged. In the outcome cycle it drives `wr_en` low and `rejected` high, and `rejected` drops in the following cycle. `wr_en` and `rejected` are never high together.
- R7: In modes 1 and 2 a granted write has `wr_len` = 1 whatever `req_len` is; any further bytes of the request are discarded. In mode 0 `wr_len` equals `req_len`. A refused request has `wr_len` = 0.
- R8: Mode code 0 (open) always grants and writes the request data unchanged.
- R9: Mode code 3 (modify-forbidden) refuses every request.
- R10: Mode code 2 (program-only) always grants and writes the old target byte ANDed with the request data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_addr | input | ADDR_W | Byte address of the write |
| req_data | input | PAGE_BYTES | First data byte of the request |
| req_len | input | LEN_W | Requested byte count |
| req_mode | input | 2 | Zone protection mode: 0 open, 1 write-lock, 2 program-only, 3 modify-forbidden |
| rd_en | output | 1 | Array read strobe |
| rd_addr | output | ADDR_W | Array read address |
| rd_data | input | PAGE_BYTES | Array read data, one cycle after `rd_en` |
| wr_en | output | 1 | Gated write strobe to the array |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | PAGE_BYTES | Value to store |
| wr_len | output | LEN_W | Byte count granted to the write |
| rejected | output | 1 | One-cycle pulse for a refused request |

## Verification
On every cycle, the in-line assertions check four things: grant and rejection are mutually exclusive, a rejection lasts one pulse, a write-lock read targets the page's first byte, and lock-byte or program-only writes never set a bit that was clear in the byte read. They also check that frozen bytes and forbidden zones always yield a rejection, and that gated modes never grant more than one byte. What these properties cannot show is that the array really ends up holding the right values across a sequence of requests. Examples are a lock byte that freezes itself and then refuses later writes, and a page where the mixed lock pattern lets one sibling through while it blocks others. Only the bench's scenarios against its own memory model expose those.

// File: rtl/wlg_pkg.sv
package wlg_pkg;

    // Zone protection modes as delivered by the command decoder.
    typedef enum logic [1:0] {
        MODE_OPEN   = 2'd0,
        MODE_LOCK   = 2'd1,
        MODE_PROG   = 2'd2,
        MODE_FORBID = 2'd3
    } zone_mode_e;

    // Sequencing of one request.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_ISSUE  = 2'd2
    } stage_e;

    // What the issue stage does with the captured request.
    typedef enum logic [1:0] {
        ACT_WRITE_NEW = 2'd0,
        ACT_WRITE_AND = 2'd1,
        ACT_REJECT    = 2'd2
    } action_e;

    // Modes whose decision depends on a byte already in the array.
    function automatic logic needs_read(zone_mode_e m);
        return (m == MODE_LOCK) || (m == MODE_PROG);
    endfunction

    // Only the open mode keeps a multi-byte length.
    function automatic logic keeps_length(zone_mode_e m);
        return m == MODE_OPEN;
    endfunction

endpackage

// File: rtl/wlg_intake.sv
module wlg_intake
    import wlg_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 8,
    parameter int MAX_LEN    = 16,
    localparam int DATA_W    = PAGE_BYTES,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [LEN_W-1:0]  req_len,
    input  zone_mode_e        req_mode,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              in_lookup,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data,
    output logic [LEN_W-1:0]  cap_len,
    output zone_mode_e        cap_mode
);

    stage_e stage_q;
    logic   take;

    assign req_ready = (stage_q == ST_IDLE);
    assign take      = req_valid && req_ready;
    assign in_lookup = (stage_q == ST_LOOKUP);

    // Write-lock reads the page head, program-only reads the target itself.
    assign rd_en   = take && needs_read(req_mode);
    assign rd_addr = (req_mode == MODE_LOCK)
                   ? {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}}
                   : req_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= ST_IDLE;
            cap_addr <= '0;
            cap_data <= '0;
            cap_len  <= '0;
            cap_mode <= MODE_OPEN;
        end else begin
            case (stage_q)
                ST_IDLE: if (take) begin
                    stage_q  <= ST_LOOKUP;
                    cap_addr <= req_addr;
                    cap_data <= req_data;
                    cap_len  <= req_len;
                    cap_mode <= req_mode;
                end
                ST_LOOKUP: stage_q <= ST_ISSUE;
                default:   stage_q <= ST_IDLE;
            endcase
        end
    end

    p_busy_after_take_r2: assert property (@(posedge clk) disable iff (rst)
        take |=> !req_ready);

    p_page_head_read_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && req_mode == MODE_LOCK) |-> (rd_addr[OFS_W-1:0] == '0)
            && (rd_addr[ADDR_W-1:OFS_W] == req_addr[ADDR_W-1:OFS_W]));

    p_no_read_unneeded_r9: assert property (@(posedge clk) disable iff (rst)
        (req_mode == MODE_FORBID || req_mode == MODE_OPEN) |-> !rd_en);

endmodule

// File: rtl/wlg_judge.sv
module wlg_judge
    import wlg_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    localparam int DATA_W    = PAGE_BYTES,
    localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
    input  zone_mode_e        mode,
    input  logic [OFS_W-1:0]  offset,
    input  logic [DATA_W-1:0] old_byte,
    output action_e           act
);

    logic guard_bit;

    // Bit k of the page head guards byte k; zero means frozen.
    assign guard_bit = old_byte[offset];

    always_comb begin
        unique case (mode)
            MODE_OPEN:   act = ACT_WRITE_NEW;
            MODE_FORBID: act = ACT_REJECT;
            MODE_PROG:   act = ACT_WRITE_AND;
            default: begin
                if (!guard_bit)          act = ACT_REJECT;
                else if (offset == '0)   act = ACT_WRITE_AND;
                else                     act = ACT_WRITE_NEW;
            end
        endcase
    end

endmodule

// File: rtl/wlock_guard.sv
module wlock_guard
    import wlg_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 8,
    parameter int MAX_LEN    = 16,
    localparam int DATA_W    = PAGE_BYTES,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [1:0]        req_mode,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [LEN_W-1:0]  wr_len,
    output logic              rejected
);

    logic              in_lookup;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic [LEN_W-1:0]  cap_len;
    zone_mode_e        cap_mode;
    action_e           act;
    logic [OFS_W-1:0]  cap_ofs;

    assign cap_ofs = cap_addr[OFS_W-1:0];

    wlg_intake #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .MAX_LEN(MAX_LEN)
    ) u_intake (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_addr (req_addr),
        .req_data (req_data),
        .req_len  (req_len),
        .req_mode (zone_mode_e'(req_mode)),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .in_lookup(in_lookup),
        .cap_addr (cap_addr),
        .cap_data (cap_data),
        .cap_len  (cap_len),
        .cap_mode (cap_mode)
    );

    wlg_judge #(.PAGE_BYTES(PAGE_BYTES)) u_judge (
        .mode    (cap_mode),
        .offset  (cap_ofs),
        .old_byte(rd_data),
        .act     (act)
    );

    // Issue register: outcome is valid for the one cycle after lookup.
    always_ff @(posedge clk) begin
        if (rst || !in_lookup) begin
            wr_en    <= 1'b0;
            rejected <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            wr_len   <= '0;
        end else begin
            wr_addr <= cap_addr;
            unique case (act)
                ACT_WRITE_NEW: begin
                    wr_en    <= 1'b1;
                    rejected <= 1'b0;
                    wr_data  <= cap_data;
                end
                ACT_WRITE_AND: begin
                    wr_en    <= 1'b1;
                    rejected <= 1'b0;
                    wr_data  <= cap_data & rd_data;
                end
                default: begin
                    wr_en    <= 1'b0;
                    rejected <= 1'b1;
                    wr_data  <= '0;
                end
            endcase
            if (act == ACT_REJECT)          wr_len <= '0;
            else if (keeps_length(cap_mode)) wr_len <= cap_len;
            else                            wr_len <= LEN_W'(1);
        end
    end

    p_grant_xor_refuse_r6: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rejected));

    p_refuse_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rejected |=> !rejected);

    p_outcome_after_lookup_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en || rejected) |-> $past(in_lookup));

    p_frozen_byte_refused_r4: assert property (@(posedge clk) disable iff (rst)
        (in_lookup && cap_mode == MODE_LOCK && !rd_data[cap_ofs])
            |=> (rejected && !wr_en));

    p_head_only_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (in_lookup && cap_mode == MODE_LOCK && cap_ofs == '0 && rd_data[0])
            |=> (wr_en && ((wr_data & ~$past(rd_data)) == '0)));

    p_gated_single_byte_r7: assert property (@(posedge clk) disable iff (rst)
        (in_lookup && cap_mode != MODE_OPEN) |=> (wr_len <= LEN_W'(1)));

    p_forbidden_refused_r9: assert property (@(posedge clk) disable iff (rst)
        (in_lookup && cap_mode == MODE_FORBID) |=> rejected);

    p_program_only_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (in_lookup && cap_mode == MODE_PROG)
            |=> (wr_en && ((wr_data & ~$past(rd_data)) == '0)));

endmodule

// File: tb/test_wlock_guard.sv
module test_wlock_guard;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 10;
    localparam int PB         = 8;
    localparam int MAX_LEN    = 16;
    localparam int LEN_W      = $clog2(MAX_LEN + 1);
    localparam int MEM_N      = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [PB-1:0]     req_data = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [1:0]        req_mode = 2'd0;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [PB-1:0]     rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [PB-1:0]     wr_data;
    logic [LEN_W-1:0]  wr_len;
    logic              rejected;

    logic              load_en = 1'b0;
    logic [5:0]        load_addr = '0;
    logic [7:0]        load_val = '0;
    logic [7:0]        mem [0:MEM_N-1];

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wlock_guard #(.ADDR_W(ADDR_W), .PAGE_BYTES(PB), .MAX_LEN(MAX_LEN)) i_wlock_guard (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_len(req_len), .req_mode(req_mode),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_len(wr_len),
        .rejected(rejected)
    );

    // Bench-owned array: registered read, write on the strobe, preload port.
    always @(posedge clk) begin
        if (load_en) mem[load_addr] <= load_val;
        if (rd_en) rd_data <= mem[rd_addr[5:0]];
        if (wr_en) mem[wr_addr[5:0]] <= wr_data;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected outcome, derived from the requirements.
    task automatic predict(input int mode, input logic [7:0] head, input logic [7:0] tgt,
                           input int ofs, input logic [7:0] d, input int len,
                           output bit we, output bit rej, output logic [7:0] wd,
                           output int wl);
        we = 1'b1; rej = 1'b0; wd = d; wl = 1;
        case (mode)
            0: wl = len;                                  // R8, R7
            3: begin we = 0; rej = 1; end                 // R9
            2: wd = tgt & d;                              // R10
            default: begin
                if (!head[ofs]) begin we = 0; rej = 1; end     // R4, R5
                else if (ofs == 0) wd = head & d;              // R5
            end
        endcase
        if (rej) begin wd = 8'h00; wl = 0; end
    endtask

    task automatic do_req(input int addr, input logic [7:0] d, input int len, input int mode);
        bit we, rej;
        logic [7:0] wd, old_t, head;
        int wl, ofs, base;
        ofs  = addr % PB;
        base = addr - ofs;
        head = mem[base];
        old_t = mem[addr];
        predict(mode, head, old_t, ofs, d, len, we, rej, wd, wl);
        @(negedge clk);
        chk(req_ready === 1'b1, "R2", "ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_addr = ADDR_W'(addr); req_data = d;
        req_len = LEN_W'(len); req_mode = 2'(mode);
        #1;
        chk(rd_en === (mode == 1 || mode == 2), "R3", "rd_en", int'(rd_en),
            int'(mode == 1 || mode == 2));
        if (mode == 1) chk(rd_addr == ADDR_W'(base), "R3", "page head address", rd_addr, base);
        if (mode == 2) chk(rd_addr == ADDR_W'(addr), "R3", "target address", rd_addr, addr);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready && !wr_en && !rejected, "R2", "lookup cycle quiet",
            {req_ready, wr_en, rejected}, 0);
        @(negedge clk);
        chk(wr_en === we, "R4", "wr_en", int'(wr_en), int'(we));
        chk(rejected === rej, "R6", "rejected", int'(rejected), int'(rej));
        chk(wr_data == wd, "R5", "wr_data", wr_data, wd);
        chk(int'(wr_len) == wl, "R7", "wr_len", wr_len, wl);
        chk(wr_addr == ADDR_W'(addr), "R2", "wr_addr", wr_addr, addr);
        chk(!req_ready, "R2", "ready low in issue", int'(req_ready), 0);
        @(negedge clk);
        chk(!wr_en && !rejected && req_ready, "R6", "outcome is one cycle",
            {wr_en, rejected, req_ready}, 1);
        chk(mem[addr] == (we ? wd : old_t), "R6", "stored byte", mem[addr],
            we ? wd : old_t);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        // Preload while in reset.
        for (int i = 0; i < MEM_N; i++) begin
            @(negedge clk);
            load_en = 1'b1; load_addr = 6'(i);
            load_val = (i == 16) ? 8'b1101_1001 : (i == 42) ? 8'h0F : 8'($urandom);
        end
        @(negedge clk);
        load_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!wr_en && !rejected && !rd_en && req_ready && wr_len == 0, "R1",
            "reset state", {wr_en, rejected, rd_en, req_ready}, 1);

        // Directed: head 11011001 on page at 16.
        do_req(17, 8'hA5, 1, 1);   // R4 frozen
        do_req(18, 8'h11, 1, 1);   // R4 frozen
        do_req(21, 8'h22, 1, 1);   // R4 frozen
        do_req(19, 8'h3C, 9, 1);   // R4 granted, R7 len cut to 1
        do_req(16, 8'hF0, 1, 1);   // R5 head AND -> D0, bit0 now 0
        do_req(16, 8'hFF, 1, 1);   // R5 head frozen itself
        chk(mem[16] == 8'hD0, "R5", "head value kept", mem[16], 8'hD0);
        do_req(40, 8'h5A, 12, 0);  // R8 open, length kept
        do_req(41, 8'h77, 3, 3);   // R9 forbidden
        do_req(42, 8'h3C, 5, 2);   // R10 program-only -> 0C, len 1

        // Constrained random mix.
        for (int n = 0; n < 400; n++) begin
            int r, mode;
            r = $urandom_range(0, 9);
            mode = (r < 5 || r == 9) ? 1 : (r < 7) ? 0 : (r == 7) ? 2 : 3;
            do_req($urandom_range(0, MEM_N - 1), 8'($urandom), $urandom_range(1, MAX_LEN), mode);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule